// File: doc/BRIEF.md
# SPI Serial Shift Engine with Selectable Bit Order

This block is the data path of an SPI port that can act as master or as slave. It moves fixed 32-bit frames with no parity bit. A word handed over on the transmit side is copied into one shift register, and the frame starts at once. That register always shifts the same way: new serial bits enter at bit 0 and the outgoing bit is taken from the top bit. Least-significant-bit-first order is not made by changing the shift direction. Instead the word is mirrored bit for bit when it enters the register. When the frame ends, the collected word is mirrored again on its way to the receive side.

Serial timing is supplied from outside as two one-cycle strobes that mark the two edges of the serial clock. On the drive strobe the next outgoing bit is presented. On the sample strobe the incoming bit is captured and the register shifts. After 32 sample strobes the received word is published together with a one-cycle valid pulse. The master/slave select routes the outgoing bit to the MOSI or the MISO line and takes the incoming bit from the other line.

The controller has three states. IDLE holds no frame. SHIFT runs a frame. DONE lasts one cycle and publishes the received word. The transitions are: IDLE to SHIFT on a load request (frame start); SHIFT to DONE on the 32nd sample strobe (frame end); DONE to SHIFT when a load is held or requested (back-to-back start); DONE to IDLE otherwise (release).

Top module: `spi_bitorder_engine`

## Requirements
- R1: After reset `busy`, `rx_valid`, `mosi_out`, `miso_out` and `rx_word` are all 0.
- R2: With `lsb_first`=0 at frame start, the k-th drive strobe of a frame (k = 0..31) presents transmit word bit 31-k on the serial output.
- R3: With `lsb_first`=1 at frame start, the k-th drive strobe presents transmit word bit k on the serial output.
- R4: With `lsb_first`=0, the bit captured at the k-th sample strobe (k = 0..31) appears in `rx_word` bit 31-k.
- R5: With `lsb_first`=1, the bit captured at the k-th sample strobe appears in `rx_word` bit k.
- R6: `rx_valid` is high for exactly one cycle, in the cycle right after the clock edge that takes the 32nd sample strobe of a frame. `busy` is high from the cycle after a load until that pulse, and it drops to 0 in the following cycle unless a new frame starts.
- R7: A `tx_load` pulse given while a frame is running does not disturb that frame. The held word starts the next frame directly from DONE, and `busy` stays high.
- R8: A change of `lsb_first` during a running frame has no effect on that frame's received word.
- R9: With `is_master`=1 the outgoing bit is driven on `mosi_out`, `miso_out` stays 0, and input is taken from `miso_in`. With `is_master`=0 the outgoing bit is driven on `miso_out`, `mosi_out` stays 0, and input is taken from `mosi_in`.
- R10: Strobes that arrive while no frame is running are ignored: `busy` and `rx_valid` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| is_master | input | 1 | 1 = master routing, 0 = slave routing |
| lsb_first | input | 1 | Bit order, captured when a frame starts |
| tx_word | input | FRAME_BITS | Word from the transmit buffer |
| tx_load | input | 1 | One-cycle request to send `tx_word` |
| sck_drive | input | 1 | Strobe for the serial clock edge that launches the next output bit |
| sck_sample | input | 1 | Strobe for the serial clock edge that captures the input bit |
| mosi_in | input | 1 | MOSI line as seen by the block (input when slave) |
| miso_in | input | 1 | MISO line as seen by the block (input when master) |
| mosi_out | output | 1 | Serial output when master |
| miso_out | output | 1 | Serial output when slave |
| rx_word | output | FRAME_BITS | Word written to the receive buffer |
| rx_valid | output | 1 | One-cycle pulse when `rx_word` is updated |
| busy | output | 1 | A frame is running or just completing |

## Verification
The bench builds the block with its default FRAME_BITS of 32. At that width the 6-bit bit counter runs up to its terminal count, so the 32nd-strobe completion and the full mirror of all 32 bit positions are reached in both orders. Walking-one and mixed patterns are sent in both master and slave routing. A held load is chained straight into a back-to-back frame, and the bit order is flipped in the middle of a frame.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_DONE  = 2'd2
    } eng_state_t;
endpackage

// File: rtl/spi_eng_bitrev.sv
module spi_eng_bitrev #(
    parameter int W = 32
) (
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    for (genvar i = 0; i < W; i++) begin : g_mirror
        assign dout[i] = din[W-1-i];
    end
endmodule

// File: rtl/spi_eng_fsm.sv
module spi_eng_fsm
    import spi_eng_pkg::*;
#(
    parameter int W = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tx_load,
    input  logic pend_valid,
    input  logic sck_drive,
    input  logic sck_sample,
    output logic start,
    output logic drive_en,
    output logic shift_en,
    output logic last_bit,
    output logic rx_valid,
    output logic busy
);
    localparam int CNT_W = $clog2(W + 1);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(W - 1);

    eng_state_t state_q, state_d;
    logic [CNT_W-1:0] cnt_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (tx_load) state_d = ST_SHIFT;
            ST_SHIFT: if (sck_sample && cnt_q == LAST_IDX) state_d = ST_DONE;
            ST_DONE:  state_d = (tx_load || pend_valid) ? ST_SHIFT : ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        start    = 1'b0;
        drive_en = 1'b0;
        shift_en = 1'b0;
        last_bit = 1'b0;
        rx_valid = 1'b0;
        busy     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                start = tx_load;
            end
            ST_SHIFT: begin
                busy     = 1'b1;
                drive_en = sck_drive;
                shift_en = sck_sample;
                last_bit = sck_sample && (cnt_q == LAST_IDX);
            end
            ST_DONE: begin
                busy     = 1'b1;
                rx_valid = 1'b1;
                start    = tx_load || pend_valid;
            end
            default: ;
        endcase
    end

    // sampled-bit counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        cnt_q <= '0;
        else if (start)    cnt_q <= '0;
        else if (shift_en) cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/spi_eng_datapath.sv
module spi_eng_datapath #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         is_master,
    input  logic         lsb_first,
    input  logic [W-1:0] tx_word,
    input  logic         tx_load,
    input  logic         start,
    input  logic         drive_en,
    input  logic         shift_en,
    input  logic         last_bit,
    input  logic         mosi_in,
    input  logic         miso_in,
    output logic         pend_valid,
    output logic         mosi_out,
    output logic         miso_out,
    output logic [W-1:0] rx_word
);
    logic [W-1:0] sr_q, pend_q, load_src, load_mirror, sr_next, rx_mirror;
    logic         lsb_q, dout_q, din;

    assign load_src = pend_valid ? pend_q : tx_word;
    assign din      = is_master ? miso_in : mosi_in;
    assign sr_next  = {sr_q[W-2:0], din};

    spi_eng_bitrev #(.W(W)) u_tx_mirror (.din(load_src), .dout(load_mirror));
    spi_eng_bitrev #(.W(W)) u_rx_mirror (.din(sr_next),  .dout(rx_mirror));

    // shift register and frame order
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q  <= '0;
            lsb_q <= 1'b0;
        end else if (start) begin
            sr_q  <= lsb_first ? load_mirror : load_src;
            lsb_q <= lsb_first;
        end else if (shift_en) begin
            sr_q  <= sr_next;
        end
    end

    // held load request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_valid <= 1'b0;
            pend_q     <= '0;
        end else if (start && pend_valid) begin
            pend_valid <= tx_load;
            if (tx_load) pend_q <= tx_word;
        end else if (tx_load && !start) begin
            pend_valid <= 1'b1;
            pend_q     <= tx_word;
        end
    end

    // launched output bit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        dout_q <= 1'b0;
        else if (drive_en) dout_q <= sr_q[W-1];
    end

    // receive buffer copy
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        rx_word <= '0;
        else if (last_bit) rx_word <= lsb_q ? rx_mirror : sr_next;
    end

    assign mosi_out = is_master  & dout_q;
    assign miso_out = !is_master & dout_q;
endmodule

// File: rtl/spi_bitorder_engine.sv
module spi_bitorder_engine #(
    parameter int FRAME_BITS = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  is_master,
    input  logic                  lsb_first,
    input  logic [FRAME_BITS-1:0] tx_word,
    input  logic                  tx_load,
    input  logic                  sck_drive,
    input  logic                  sck_sample,
    input  logic                  mosi_in,
    input  logic                  miso_in,
    output logic                  mosi_out,
    output logic                  miso_out,
    output logic [FRAME_BITS-1:0] rx_word,
    output logic                  rx_valid,
    output logic                  busy
);
    logic start, drive_en, shift_en, last_bit, pend_valid;

    spi_eng_fsm #(.W(FRAME_BITS)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_load    (tx_load),
        .pend_valid (pend_valid),
        .sck_drive  (sck_drive),
        .sck_sample (sck_sample),
        .start      (start),
        .drive_en   (drive_en),
        .shift_en   (shift_en),
        .last_bit   (last_bit),
        .rx_valid   (rx_valid),
        .busy       (busy)
    );

    spi_eng_datapath #(.W(FRAME_BITS)) u_dp (
        .clk        (clk),
        .rst_n      (rst_n),
        .is_master  (is_master),
        .lsb_first  (lsb_first),
        .tx_word    (tx_word),
        .tx_load    (tx_load),
        .start      (start),
        .drive_en   (drive_en),
        .shift_en   (shift_en),
        .last_bit   (last_bit),
        .mosi_in    (mosi_in),
        .miso_in    (miso_in),
        .pend_valid (pend_valid),
        .mosi_out   (mosi_out),
        .miso_out   (miso_out),
        .rx_word    (rx_word)
    );
endmodule

// File: rtl/spi_bitorder_engine_chk.sv
module spi_bitorder_engine_chk (
    input logic clk,
    input logic rst_n,
    input logic is_master,
    input logic tx_load,
    input logic sck_drive,
    input logic sck_sample,
    input logic mosi_out,
    input logic miso_out,
    input logic rx_valid,
    input logic busy
);
    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid); // R6
    AST_VALID_AFTER_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_valid) |-> $past(sck_sample)); // R6
    AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !rx_valid) |=> busy); // R6
    AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !rx_valid); // R10
    AST_CHAIN_START: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && tx_load) |=> (busy && !rx_valid)); // R7
    AST_MOSI_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (is_master && !sck_drive) |=> (!is_master || $stable(mosi_out))); // R2
    AST_ONE_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
        !(mosi_out && miso_out)); // R9
endmodule

bind spi_bitorder_engine spi_bitorder_engine_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .is_master  (is_master),
    .tx_load    (tx_load),
    .sck_drive  (sck_drive),
    .sck_sample (sck_sample),
    .mosi_out   (mosi_out),
    .miso_out   (miso_out),
    .rx_valid   (rx_valid),
    .busy       (busy)
);

// File: tb/spi_bitorder_engine_tb.sv
module spi_bitorder_engine_tb;
    localparam int CLK_PERIOD = 10;
    localparam int W = 32;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         is_master = 1'b1;
    logic         lsb_first = 1'b0;
    logic [W-1:0] tx_word = '0;
    logic         tx_load = 1'b0;
    logic         sck_drive = 1'b0;
    logic         sck_sample = 1'b0;
    logic         mosi_in = 1'b0;
    logic         miso_in = 1'b0;
    logic         mosi_out, miso_out, rx_valid, busy;
    logic [W-1:0] rx_word;

    int checks = 0;
    int errors = 0;
    logic [W-1:0] exp_q[$];
    logic         valid_prev = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_bitorder_engine #(.FRAME_BITS(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .is_master(is_master), .lsb_first(lsb_first),
        .tx_word(tx_word), .tx_load(tx_load), .sck_drive(sck_drive),
        .sck_sample(sck_sample), .mosi_in(mosi_in), .miso_in(miso_in),
        .mosi_out(mosi_out), .miso_out(miso_out), .rx_word(rx_word),
        .rx_valid(rx_valid), .busy(busy)
    );

    task automatic check(input bit ok, input string tag, input logic [W-1:0] act,
                         input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [W-1:0] mirror(input logic [W-1:0] v);
        logic [W-1:0] r;
        for (int i = 0; i < W; i++) r[i] = v[W-1-i];
        return r;
    endfunction

    // monitor: pops expected receive words as pulses appear
    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_valid) begin
                if (valid_prev)
                    check(1'b0, "R6 pulse longer than one cycle", 1, 0);
                if (exp_q.size() == 0) begin
                    check(1'b0, "R10 unexpected rx_valid", rx_word, '0);
                end else begin
                    logic [W-1:0] e;
                    e = exp_q.pop_front();
                    check(rx_word === e, "R4/R5/R8 received word", rx_word, e);
                end
            end
            valid_prev = rx_valid;
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // one frame: stream[k] is the bit presented at the k-th sample strobe
    task automatic run_frame(input logic [W-1:0] tx, input logic [W-1:0] stream,
                             input bit lsb, input bit master, input bit do_load,
                             input bit flip_mid, input bit hold_next,
                             input logic [W-1:0] next_word);
        logic [W-1:0] exp_rx;
        is_master = master;
        if (do_load) begin
            tx_word = tx; lsb_first = lsb; tx_load = 1'b1;
            tick();
            tx_load = 1'b0;
        end
        exp_rx = lsb ? stream : mirror(stream);
        exp_q.push_back(exp_rx);
        for (int i = 0; i < W; i++) begin
            logic eb;
            sck_drive = 1'b1;
            tick();
            sck_drive = 1'b0;
            eb = lsb ? tx[i] : tx[W-1-i];
            if (master) begin
                check(mosi_out === eb, lsb ? "R3 mosi bit" : "R2 mosi bit", mosi_out, eb);
                check(miso_out === 1'b0, "R9 miso idle", miso_out, 0);
                miso_in = stream[i]; mosi_in = ~stream[i];
            end else begin
                check(miso_out === eb, lsb ? "R3 miso bit" : "R2 miso bit", miso_out, eb);
                check(mosi_out === 1'b0, "R9 mosi idle", mosi_out, 0);
                mosi_in = stream[i]; miso_in = ~stream[i];
            end
            if (flip_mid && i == 10) lsb_first = ~lsb_first;
            if (hold_next && i == 5) begin
                tx_word = next_word; tx_load = 1'b1;
                tick();
                tx_load = 1'b0;
                check(busy === 1'b1, "R7 busy during held load", busy, 1);
            end
            sck_sample = 1'b1;
            tick();
            sck_sample = 1'b0;
        end
        check(rx_valid === 1'b1 && busy === 1'b1, "R6 valid after last sample",
              {rx_valid, busy}, 2'b11);
        if (flip_mid) lsb_first = lsb;
        tick();
        if (hold_next) begin
            check(busy === 1'b1 && rx_valid === 1'b0, "R7 next frame started",
                  {busy, rx_valid}, 2'b10);
        end else begin
            check(busy === 1'b0 && rx_valid === 1'b0, "R6 back to idle",
                  {busy, rx_valid}, 2'b00);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check(busy === 0 && rx_valid === 0 && mosi_out === 0 && miso_out === 0,
              "R1 reset outputs", {busy, rx_valid, mosi_out, miso_out}, 0);
        check(rx_word === '0, "R1 reset rx_word", rx_word, '0);
        rst_n = 1'b1;
        tick();

        // R10: strobes with no frame running
        for (int i = 0; i < 5; i++) begin
            sck_drive = 1'b1; sck_sample = 1'b1;
            tick();
            sck_drive = 1'b0; sck_sample = 1'b0;
            check(busy === 0 && rx_valid === 0, "R10 idle strobes ignored",
                  {busy, rx_valid}, 0);
        end

        // R2/R4 master, MSB first
        run_frame(32'hA5C3_0F81, 32'h0000_0001, 0, 1, 1, 0, 0, '0);
        // R3/R5 master, LSB first
        run_frame(32'hA5C3_0F81, 32'h0000_0001, 1, 1, 1, 0, 0, '0);
        // R9 slave routing, both orders
        run_frame(32'h1234_5678, 32'hDEAD_BEEF, 0, 0, 1, 0, 0, '0);
        run_frame(32'h8000_0001, 32'h8000_0000, 1, 0, 1, 0, 0, '0);
        // R8: order flipped in the middle of a frame
        run_frame(32'h0F0F_3C3C, 32'hC001_D00D, 1, 1, 1, 1, 0, '0);
        run_frame(32'hF000_000F, 32'h1357_9BDF, 0, 1, 1, 1, 0, '0);
        // R7: held load chains into a back-to-back frame
        run_frame(32'h0000_FFFF, 32'h55AA_33CC, 1, 1, 1, 0, 1, 32'h6B2D_9E41);
        run_frame(32'h6B2D_9E41, 32'hFFFF_0000, 1, 1, 0, 0, 0, '0);

        repeat (3) tick();
        check(exp_q.size() == 0, "R6 all frames delivered", exp_q.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule